// File: doc/BRIEF.md
# Printer carriage-control sequencer

This block sits between an I/O channel and a line-printer mechanism. It takes one 8-bit print command, gathers the line data that the channel streams in, and assembles an output line in a local buffer. Depending on the command, paper-motion characters (carriage return, line feeds or a form feed) go into the buffer ahead of the data, after it, or both. Once the line is complete, the block plays the buffer out as a byte stream toward the print mechanism.

A line-per-page counter follows the paper position. Every inserted line feed advances it. A form feed returns it to zero. Each released line advances it by one more. When a released line carries the counter past the configured page length, the counter wraps to zero and the completion status reports a unit exception. Commands the block does not recognise finish at once with a unit-check status and produce no output.

Top module: `cc_line_sequencer`

## Requirements
- R1: The accepted command codes are 0x01, 0x05, 0x15, 0x25, 0x35, 0x45, 0x85, 0x0D, 0x1D, 0x2D, 0x3D, 0x4D, 0x03, 0x17, 0x27, 0x37 and 0x47. Any other code produces no output byte and completes with status 4'b1011 (bit 3 unit check, bit 2 unit exception, bit 1 device end, bit 0 channel end).
- R2: Motion is placed before the data when the two low bits of the code are both 1, or when the low nibble is 0xD.
- R3: The high nibble selects the motion. 0 or 8 gives one CR (0x0D). 1, 2 or 3 gives that many LF (0x0A). 4 gives the three bytes CR, LF, FF (0x0D 0x0A 0x0C).
- R4: A code with low nibble 0x5 appends the motion selected by its high nibble after the data. A code with low nibble 0xD always appends exactly one CR after the data.
- R5: Codes with low nibble 0x1, 0x5 or 0xD copy channel bytes into the line in arrival order. 0x01 adds no control byte. Codes with low nibble 0x3 or 0x7 take no input byte: in_ready stays low for the whole command.
- R6: Data intake stops when the channel marks a byte as last, or when the line holds 156 bytes (control bytes included). Any following channel bytes are left untaken.
- R7: Each inserted LF adds one to line_count. A form feed leaves line_count at zero. Releasing the line adds one more.
- R8: If the release increment would take line_count above the page length, line_count becomes zero and the status is 4'b0111. Otherwise the status is 4'b0011.
- R9: The page length resets to 66. A write of a value from 20 to 100 replaces it and clears line_count. Any other value is ignored and leaves line_count unchanged.
- R10: Output bytes hold their value while out_ready is low. done_valid is a one-cycle pulse. out_eol pulses with it for every accepted command.
- R11: After the completion pulse the block is idle and cmd_ready is high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and accepting a command |
| cmd_code | input | 8 | Command code |
| lpp_wr | input | 1 | Page-length write strobe |
| lpp_val | input | CNT_W | Page-length value |
| in_valid | input | 1 | Channel data byte offered |
| in_ready | output | 1 | Channel data byte accepted |
| in_data | input | 8 | Channel data byte |
| in_last | input | 1 | Marks the final channel byte of the line |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Print mechanism takes the byte |
| out_data | output | 8 | Output byte |
| out_eol | output | 1 | Line-end pulse |
| done_valid | output | 1 | Completion pulse |
| done_status | output | 4 | {unit check, unit exception, device end, channel end} |
| line_count | output | CNT_W | Lines advanced on the current page |
| lpp | output | CNT_W | Active page length |

## Verification
An invalid command reaches done_valid one clock edge after it is accepted. For an accepted command, done_valid rises two edges after the last output byte is taken: one edge to see the emptied buffer and one to enter completion. line_count is updated on that same edge. The bench never counts cycles toward these results. It follows the handshakes at each falling edge, records output bytes whenever out_valid and out_ready are both high, and samples status, out_eol and line_count at the falling edge where done_valid is first seen. It checks cmd_ready at the falling edge after that.

// File: rtl/cc_pkg.sv
package cc_pkg;

  typedef enum logic [2:0] {
    MOT_NONE, MOT_CR, MOT_LF1, MOT_LF2, MOT_LF3, MOT_FF
  } motion_t;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_DATA, S_POST, S_EMIT, S_DONE
  } seq_state_t;

  typedef struct packed {
    logic    legal;
    logic    pre_en;
    logic    post_en;
    logic    print_en;
    logic    clear_after;
    motion_t pre_m;
    motion_t post_m;
  } cmd_t;

  localparam logic [7:0] CH_CR = 8'h0D;
  localparam logic [7:0] CH_LF = 8'h0A;
  localparam logic [7:0] CH_FF = 8'h0C;

  function automatic motion_t motion_of(input logic [3:0] hi);
    case (hi)
      4'h0, 4'h8: motion_of = MOT_CR;
      4'h1:       motion_of = MOT_LF1;
      4'h2:       motion_of = MOT_LF2;
      4'h3:       motion_of = MOT_LF3;
      4'h4:       motion_of = MOT_FF;
      default:    motion_of = MOT_NONE;
    endcase
  endfunction

  function automatic logic [1:0] motion_len(input motion_t m);
    case (m)
      MOT_CR, MOT_LF1: motion_len = 2'd1;
      MOT_LF2:         motion_len = 2'd2;
      MOT_LF3, MOT_FF: motion_len = 2'd3;
      default:         motion_len = 2'd0;
    endcase
  endfunction

  function automatic logic [7:0] motion_char(input motion_t m, input logic [1:0] idx);
    case (m)
      MOT_CR:  motion_char = CH_CR;
      MOT_FF:  motion_char = (idx == 2'd0) ? CH_CR : (idx == 2'd1) ? CH_LF : CH_FF;
      MOT_NONE: motion_char = 8'h00;
      default: motion_char = CH_LF;
    endcase
  endfunction

  function automatic cmd_t decode_cmd(input logic [7:0] code);
    cmd_t c;
    logic [3:0] lo, hi;
    lo = code[3:0];
    hi = code[7:4];
    case (lo)
      4'h1:    c.legal = (hi == 4'h0);
      4'h5:    c.legal = (hi <= 4'h4) || (hi == 4'h8);
      4'hD:    c.legal = (hi <= 4'h4);
      4'h3:    c.legal = (hi == 4'h0);
      4'h7:    c.legal = (hi >= 4'h1) && (hi <= 4'h4);
      default: c.legal = 1'b0;
    endcase
    c.pre_en      = (code[1:0] == 2'b11) || (lo == 4'hD);
    c.post_en     = (lo == 4'h5) || (lo == 4'hD);
    c.print_en    = (lo == 4'h1) || (lo == 4'h5) || (lo == 4'hD);
    c.clear_after = (code == 8'h85);
    c.pre_m       = motion_of(hi);
    c.post_m      = (lo == 4'hD) ? MOT_CR : motion_of(hi);
    return c;
  endfunction

endpackage

// File: rtl/cc_decode.sv
module cc_decode
  import cc_pkg::*;
(
  input  logic [7:0] code,
  output cmd_t       cmd
);

  always_comb begin
    cmd = decode_cmd(code);
  end

  // R1: every accepted code does some work and has a real motion where one is used
  always_comb begin
    if (cmd.legal) begin
      a_legal_work_r1: assert (cmd.pre_en || cmd.print_en);
      if (cmd.pre_en)  a_pre_motion_r2: assert (cmd.pre_m != MOT_NONE);
      if (cmd.post_en) a_post_motion_r4: assert (cmd.post_m != MOT_NONE);
    end
  end

endmodule

// File: rtl/cc_linebuf.sv
module cc_linebuf #(
  parameter int DEPTH = 160,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             clr,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [7:0]       rd_data
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      mem <= '{default: '0};
    end else if (wr_en && (int'(wr_addr) < DEPTH)) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = (int'(rd_addr) < DEPTH) ? mem[rd_addr] : 8'h00;

  p_write_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < DEPTH));

endmodule

// File: rtl/cc_linecount.sv
module cc_linecount #(
  parameter int CNT_W       = 7,
  parameter int LPP_MIN     = 20,
  parameter int LPP_MAX     = 100,
  parameter int LPP_DEFAULT = 66
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lpp_wr,
  input  logic [CNT_W-1:0] lpp_val,
  input  logic             lf_step,
  input  logic             ff_clear,
  input  logic             release_line,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] lpp,
  output logic             page_over
);

  function automatic logic lpp_ok(input logic [CNT_W-1:0] v);
    return (int'(v) >= LPP_MIN) && (int'(v) <= LPP_MAX);
  endfunction

  function automatic logic past_page(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] l);
    return ({1'b0, c} + 1'b1) > {1'b0, l};
  endfunction

  assign page_over = release_line && past_page(count, lpp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      lpp   <= CNT_W'(LPP_DEFAULT);
    end else if (lpp_wr && lpp_ok(lpp_val)) begin
      lpp   <= lpp_val;
      count <= '0;
    end else if (release_line) begin
      count <= page_over ? '0 : count + 1'b1;
    end else if (ff_clear) begin
      count <= '0;
    end else if (lf_step) begin
      count <= count + 1'b1;
    end
  end

  p_lpp_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(lpp) >= LPP_MIN) && (int'(lpp) <= LPP_MAX));

  p_page_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    page_over |=> (count == '0));

  p_bad_lpp_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lpp_wr && !lpp_ok(lpp_val)) |=> $stable(lpp));

endmodule

// File: rtl/cc_line_sequencer.sv
module cc_line_sequencer
  import cc_pkg::*;
#(
  parameter int BUF_DEPTH   = 160,
  parameter int LINE_LIMIT  = 156,
  parameter int LPP_MIN     = 20,
  parameter int LPP_MAX     = 100,
  parameter int LPP_DEFAULT = 66,
  parameter int CNT_W       = $clog2(LPP_MAX + 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [7:0]       cmd_code,
  input  logic             lpp_wr,
  input  logic [CNT_W-1:0] lpp_val,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_eol,
  output logic             done_valid,
  output logic [3:0]       done_status,
  output logic [CNT_W-1:0] line_count,
  output logic [CNT_W-1:0] lpp
);

  localparam int PTR_W = $clog2(BUF_DEPTH);
  localparam logic [PTR_W-1:0] LAST_DATA_POS = PTR_W'(LINE_LIMIT - 1);

  seq_state_t state;
  cmd_t       cmd_d, cmd_q;
  logic [PTR_W-1:0] wptr, rptr;
  logic [1:0]       midx;
  logic             exc_q;

  // named internal events
  motion_t          cur_m;
  logic             motion_wr, motion_last;
  logic             cmd_take, data_take, data_end;
  logic             wr_en, lf_step, ff_clear, release_line, page_over, buf_clr;
  logic [7:0]       wr_data, rd_data;

  cc_decode u_dec (
    .code (cmd_code),
    .cmd  (cmd_d)
  );

  function automatic seq_state_t first_phase(input cmd_t c);
    if (!c.legal)        return S_DONE;
    else if (c.pre_en)   return S_PRE;
    else if (c.print_en) return S_DATA;
    else if (c.post_en)  return S_POST;
    else                 return S_EMIT;
  endfunction

  function automatic seq_state_t after_pre(input cmd_t c);
    if (c.print_en)     return S_DATA;
    else if (c.post_en) return S_POST;
    else                return S_EMIT;
  endfunction

  assign cur_m       = (state == S_PRE) ? cmd_q.pre_m : cmd_q.post_m;
  assign motion_wr   = (state == S_PRE) || (state == S_POST);
  assign motion_last = (midx == (motion_len(cur_m) - 2'd1));
  assign cmd_ready   = (state == S_IDLE);
  assign cmd_take    = cmd_valid && cmd_ready;
  assign in_ready    = (state == S_DATA);
  assign data_take   = in_valid && in_ready;
  assign data_end    = data_take && (in_last || (wptr == LAST_DATA_POS));
  assign wr_en       = motion_wr || data_take;
  assign wr_data     = motion_wr ? motion_char(cur_m, midx) : in_data;
  assign lf_step     = motion_wr && (motion_char(cur_m, midx) == CH_LF);
  assign ff_clear    = motion_wr && (cur_m == MOT_FF) && motion_last;
  assign out_valid   = (state == S_EMIT) && (rptr != wptr);
  assign out_data    = rd_data;
  assign release_line = (state == S_EMIT) && (rptr == wptr);
  assign done_valid  = (state == S_DONE);
  assign done_status = {!cmd_q.legal, exc_q, 1'b1, 1'b1};
  assign out_eol     = done_valid && cmd_q.legal;
  assign buf_clr     = done_valid && cmd_q.legal && cmd_q.clear_after;

  cc_linebuf #(.DEPTH(BUF_DEPTH), .PTR_W(PTR_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wptr),
    .wr_data (wr_data),
    .clr     (buf_clr),
    .rd_addr (rptr),
    .rd_data (rd_data)
  );

  cc_linecount #(
    .CNT_W(CNT_W), .LPP_MIN(LPP_MIN), .LPP_MAX(LPP_MAX), .LPP_DEFAULT(LPP_DEFAULT)
  ) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .lpp_wr       (lpp_wr),
    .lpp_val      (lpp_val),
    .lf_step      (lf_step),
    .ff_clear     (ff_clear),
    .release_line (release_line),
    .count        (line_count),
    .lpp          (lpp),
    .page_over    (page_over)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cmd_q <= '0;
      wptr  <= '0;
      rptr  <= '0;
      midx  <= '0;
      exc_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (cmd_take) begin
          cmd_q <= cmd_d;
          wptr  <= '0;
          rptr  <= '0;
          midx  <= '0;
          exc_q <= 1'b0;
          state <= first_phase(cmd_d);
        end
        S_PRE, S_POST: begin
          wptr <= wptr + 1'b1;
          if (motion_last) begin
            midx  <= '0;
            state <= (state == S_PRE) ? after_pre(cmd_q) : S_EMIT;
          end else begin
            midx <= midx + 1'b1;
          end
        end
        S_DATA: begin
          if (data_take) wptr <= wptr + 1'b1;
          if (data_end)  state <= cmd_q.post_en ? S_POST : S_EMIT;
        end
        S_EMIT: begin
          if (out_valid && out_ready) rptr <= rptr + 1'b1;
          if (release_line) begin
            exc_q <= page_over;
            state <= S_DONE;
          end
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (!done_valid && cmd_ready));

  p_out_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_wptr_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA) |-> (int'(wptr) < LINE_LIMIT));

  p_no_intake_motion_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> cmd_q.print_en);

  p_count_in_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (line_count <= lpp));

  p_exc_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_status[2]) |-> (line_count == '0));

  p_reject_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_status[3]) |-> (!out_eol && !done_status[2]));

endmodule

// File: tb/cc_line_sequencer_test.sv
module cc_line_sequencer_test;

  localparam int CNT_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [7:0] cmd_code = 8'h00;
  logic lpp_wr = 1'b0;
  logic [CNT_W-1:0] lpp_val = '0;
  logic in_valid = 1'b0, in_ready, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic out_valid, out_ready = 1'b0, out_eol, done_valid;
  logic [7:0] out_data;
  logic [3:0] done_status;
  logic [CNT_W-1:0] line_count, lpp;

  int n_checks = 0, n_fail = 0, cycles = 0;
  int m_cnt = 0, m_lpp = 66;
  logic [7:0] data_arr [0:255];

  always #4 clk = ~clk;

  cc_line_sequencer uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .lpp_wr(lpp_wr), .lpp_val(lpp_val),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_eol(out_eol),
    .done_valid(done_valid), .done_status(done_status),
    .line_count(line_count), .lpp(lpp)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit legal_b(input logic [7:0] c);
    return c inside {8'h01, 8'h03, 8'h05, 8'h0D, 8'h15, 8'h17, 8'h1D, 8'h25, 8'h27,
                     8'h2D, 8'h35, 8'h37, 8'h3D, 8'h45, 8'h47, 8'h4D, 8'h85};
  endfunction

  // R3 and R7: expected motion bytes and counter effect
  task automatic add_motion(ref logic [7:0] q[$], input int kind);
    if (kind == 4) begin
      q.push_back(8'h0D); q.push_back(8'h0A); q.push_back(8'h0C);
      m_cnt = 0;
    end else if (kind == 0) begin
      q.push_back(8'h0D);
    end else begin
      for (int k = 0; k < kind; k++) begin
        q.push_back(8'h0A);
        m_cnt++;
      end
    end
  endtask

  task automatic run_cmd(input logic [7:0] code, input int n, input bit give_last,
                         input bit stall, input string tag);
    logic [7:0] exp[$];
    logic [7:0] got[$];
    logic [3:0] lo, hi, st, exp_st;
    bit legal, printing, saw_in_ready, eol, bytes_ok;
    int ndata, guard, kind, cnt_seen, bad_at;
    lo = code[3:0];
    hi = code[7:4];
    legal = legal_b(code);
    printing = legal && (lo == 4'h1 || lo == 4'h5 || lo == 4'hD);
    kind = (hi == 4'h8) ? 0 : int'(hi);
    ndata = 0;
    saw_in_ready = 0;
    for (int i = 0; i < n; i++) data_arr[i] = 8'($urandom);
    if (legal) begin
      if (lo == 4'h3 || lo == 4'h7 || lo == 4'hD) add_motion(exp, kind);
      if (printing) begin
        ndata = n;
        if (ndata > 156 - exp.size()) ndata = 156 - exp.size();
        for (int i = 0; i < ndata; i++) exp.push_back(data_arr[i]);
      end
      if (lo == 4'h5) add_motion(exp, kind);
      if (lo == 4'hD) exp.push_back(8'h0D);
      if (m_cnt + 1 > m_lpp) begin
        exp_st = 4'b0111; m_cnt = 0;
      end else begin
        exp_st = 4'b0011; m_cnt++;
      end
    end else begin
      exp_st = 4'b1011;
    end
    @(negedge clk);
    if (!printing) begin
      in_valid = 1'b1; in_data = 8'hEE; in_last = 1'b1;
    end
    fork
      begin
        cmd_code = code;
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
      end
      begin
        if (printing) begin
          for (int i = 0; i < ndata; i++) begin
            in_valid = 1'b1;
            in_data = data_arr[i];
            in_last = give_last && (i == ndata - 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
          end
          in_valid = 1'b0;
          in_last = 1'b0;
        end
      end
      begin
        guard = 0;
        while (1) begin
          @(negedge clk);
          out_ready = stall ? ($urandom % 3 != 0) : 1'b1;
          if (!printing && in_ready) saw_in_ready = 1;
          if (done_valid) begin
            st = done_status; eol = out_eol; cnt_seen = int'(line_count);
            break;
          end
          if (out_valid && out_ready) got.push_back(out_data);
          guard++;
          if (guard > 3000) break;
        end
      end
    join
    in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b0;
    check(guard <= 3000, "R10", "completion pulse seen", guard, 3000);
    bytes_ok = (got.size() == exp.size());
    bad_at = -1;
    if (bytes_ok) begin
      for (int i = 0; i < exp.size(); i++)
        if (got[i] !== exp[i] && bad_at < 0) bad_at = i;
    end
    check(bytes_ok, tag, $sformatf("line length code %02h", code), got.size(), exp.size());
    if (bad_at >= 0)
      check(0, tag, $sformatf("byte %0d code %02h", bad_at, code), got[bad_at], exp[bad_at]);
    check(st === exp_st, legal ? "R8" : "R1", $sformatf("status code %02h", code), st, exp_st);
    check(eol === legal, "R10", "line-end pulse", eol, legal);
    check(cnt_seen == m_cnt, "R7", $sformatf("line count code %02h", code), cnt_seen, m_cnt);
    if (!printing) check(!saw_in_ready, "R5", "no intake on motion-only or rejected", saw_in_ready, 0);
    @(negedge clk);
    check(cmd_ready === 1'b1, "R11", "idle after completion", cmd_ready, 1);
  endtask

  task automatic set_lpp(input int v);
    @(negedge clk);
    lpp_wr = 1'b1; lpp_val = CNT_W'(v);
    @(negedge clk);
    lpp_wr = 1'b0;
    if (v >= 20 && v <= 100) begin
      m_lpp = v; m_cnt = 0;
    end
    check(int'(lpp) == m_lpp, "R9", $sformatf("page length after write %0d", v), lpp, m_lpp);
    check(int'(line_count) == m_cnt, "R9", $sformatf("line count after write %0d", v), line_count, m_cnt);
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stimulus
    logic [7:0] legal_list [17];
    logic [7:0] code;
    legal_list = '{8'h01, 8'h05, 8'h15, 8'h25, 8'h35, 8'h45, 8'h85, 8'h0D, 8'h1D,
                   8'h2D, 8'h3D, 8'h4D, 8'h03, 8'h17, 8'h27, 8'h37, 8'h47};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready === 1'b1, "R11", "reset idle", cmd_ready, 1);
    check(out_valid === 1'b0 && done_valid === 1'b0, "R10", "reset outputs quiet", out_valid, 0);
    check(line_count == 0, "R7", "reset line count", line_count, 0);
    check(int'(lpp) == 66, "R9", "default page length", lpp, 66);

    // directed: every accepted code once
    foreach (legal_list[i]) begin
      code = legal_list[i];
      run_cmd(code, 3, 1, 0, (code[1:0] == 2'b11 || code[3:0] == 4'hD) ? "R2" : "R4");
    end
    run_cmd(8'h4D, 2, 1, 1, "R3");
    run_cmd(8'h47, 0, 1, 1, "R3");
    run_cmd(8'h01, 1, 1, 1, "R5");
    // rejected codes
    run_cmd(8'h00, 0, 1, 0, "R1");
    run_cmd(8'h07, 0, 1, 0, "R1");
    run_cmd(8'h55, 0, 1, 0, "R1");
    run_cmd(8'h0F, 0, 1, 0, "R1");
    run_cmd(8'h95, 0, 1, 0, "R1");
    // line limit without a last marker
    run_cmd(8'h01, 156, 0, 1, "R6");
    run_cmd(8'h1D, 155, 0, 0, "R6");
    run_cmd(8'h45, 156, 0, 1, "R6");
    // page length settings
    set_lpp(19);
    set_lpp(101);
    set_lpp(20);
    for (int i = 0; i < 24; i++) run_cmd(8'h01, 2, 1, 0, "R8");
    run_cmd(8'h35, 1, 1, 0, "R8");
    set_lpp(100);
    set_lpp(0);
    // random mix
    for (int i = 0; i < 90; i++) begin
      if ($urandom % 8 == 0) code = 8'($urandom);
      else code = legal_list[$urandom % 17];
      if ($urandom % 20 == 0) set_lpp(20 + int'($urandom % 10));
      run_cmd(code, 1 + int'($urandom % 40), 1, ($urandom % 2) == 1, "R5");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule